// File: doc/BRIEF.md
# Banked General-Register File

This block holds the general registers of a small microcontroller core and decodes a direct 8-bit register address into a physical byte location. Storage is four banks of 256 bytes. A static strap input tells the block whether the board has one register bank or several. A bank-pair bit from the status word, together with the access width, decides which bank a direct access reaches.

With one bank fitted, every access goes to bank 0. A word access ignores address bit 0. With several banks fitted, a byte access goes to the even bank of the selected pair. A word access instead uses address bit 0 to choose between the even and odd bank of the pair, so an odd word address reaches the aligned word in the odd bank.

The low window of special-function addresses is never banked. In this block those registers are plain storage. A second byte port addresses the storage by a 10-bit flat index, where bank b offset o is index b*0x100+o. Through this port any physical location can be read or written directly.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every one of the 1024 storage bytes reads as zero.
- R2: In single-bank mode (multi_bank_i=0), a byte access to direct address A reaches flat index A. The read value is zero-extended to 16 bits.
- R3: In single-bank mode, a word access to address A reaches flat indices (A & 0xFE) and (A & 0xFE)+1, so bit 0 is ignored. The word is little-endian: the low byte is at the even index and the high byte at the odd index.
- R4: In multi-bank mode, a word access to a non-window address A uses bank number {pair_sel_i, A[0]} at offset A & 0xFE, little-endian.
- R5: pair_sel_i=0 selects banks 0 and 1, and pair_sel_i=1 selects banks 2 and 3. Bank b offset o is flat index b*256+o.
- R6: In multi-bank mode, a byte access to a non-window address A uses bank {pair_sel_i, 0} at the full offset A, so bit 0 picks the byte.
- R7: Addresses 0x00 to 0x17 are never banked. In both modes and at both widths they reach bank 0, with bit 0 cleared for word accesses.
- R8: In multi-bank mode with pair_sel_i=0, a word at 0x3B and flat index 0x13A are the same storage. In single-bank mode the same word is flat 0x03A, and flat 0x13A is untouched.
- R9: A direct write takes effect at the rising clock edge only while we_i=1, and reads are combinational. With we_i=0 the storage does not change.
- R10: The flat port reads combinationally and writes one byte at the edge when flat_we_i=1. If both ports write the same byte in one cycle, the direct port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears storage |
| multi_bank_i | input | 1 | Strap: 1 = several banks fitted |
| pair_sel_i | input | 1 | Status-word bank-pair bit |
| addr_i | input | 8 | Direct register address |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| we_i | input | 1 | Direct write enable |
| wdata_i | input | 16 | Direct write data (low byte only for byte access) |
| rdata_o | output | 16 | Direct read data |
| flat_addr_i | input | 10 | Flat storage index |
| flat_we_i | input | 1 | Flat port write enable |
| flat_wdata_i | input | 8 | Flat port write data |
| flat_rdata_o | output | 8 | Flat port read data |

## Verification
Random operations vary the strap, the pair bit, the width, the address parity and the window membership. Every direct read is then compared with a byte-array model indexed the flat way, and each flat read cross-checks where the earlier writes landed. The directed cases are chosen to separate specific rules. The 0x3B against 0x13A case tells multi-bank aliasing apart from single-bank bit-dropping. Window addresses under pair 1 tell "never banked" apart from "banked to the even bank". Simultaneous writes to one byte settle which port has priority.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned AW        = 8;
  localparam int unsigned DW        = 8;
  localparam int unsigned BANK_BITS = 2;
  localparam int unsigned FW        = AW + BANK_BITS;
  localparam int unsigned DEPTH     = 1 << FW;
  localparam logic [AW-1:0] WIN_LAST = 8'h17;

  // Flat index of the low byte of a direct access.
  function automatic logic [FW-1:0] map_low(input logic [AW-1:0] a,
                                            input logic wide,
                                            input logic multi,
                                            input logic pair);
    logic [AW-1:0] off;
    logic [BANK_BITS-1:0] bank;
    off  = wide ? {a[AW-1:1], 1'b0} : a;
    bank = '0;
    if (multi && (a > WIN_LAST))
      bank = wide ? {pair, a[0]} : {pair, 1'b0};
    return {bank, off};
  endfunction
endpackage

// File: rtl/brf_addr_map.sv
module brf_addr_map
  import brf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wide,
  input  logic          multi,
  input  logic          pair,
  output logic [FW-1:0] idx_lo,
  output logic [FW-1:0] idx_hi,
  output logic          win_hit
);
  assign win_hit = (addr <= WIN_LAST);
  assign idx_lo  = map_low(addr, wide, multi, pair);
  assign idx_hi  = {idx_lo[FW-1:1], 1'b1};

  // R7: the special-function window always lands in bank 0
  a_r7_window_unbanked: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (idx_lo[FW-1:AW] == '0));
  // R3: the single-bank strap never leaves bank 0
  a_r3_single_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    !multi |-> (idx_lo[FW-1:AW] == '0));
  // R4: word accesses are even-aligned, high byte right above
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> (!idx_lo[0] && idx_hi == idx_lo + 1'b1));
  // R6: multi-bank byte accesses use the even bank of the pair
  a_r6_byte_even_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && !wide && !win_hit) |-> (idx_lo[FW-1:AW] == {pair, 1'b0}));
endmodule

// File: rtl/brf_storage.sv
module brf_storage
  import brf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] lo_idx,
  input  logic [FW-1:0] hi_idx,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [DW-1:0] lo_wd,
  input  logic [DW-1:0] hi_wd,
  output logic [DW-1:0] lo_rd,
  output logic [DW-1:0] hi_rd,
  input  logic [FW-1:0] fl_idx,
  input  logic          fl_we,
  input  logic [DW-1:0] fl_wd,
  output logic [DW-1:0] fl_rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (fl_we) mem[fl_idx] <= fl_wd;
      if (lo_we) mem[lo_idx] <= lo_wd;   // direct port wins (R10)
      if (hi_we) mem[hi_idx] <= hi_wd;
    end
  end

  assign lo_rd = mem[lo_idx];
  assign hi_rd = mem[hi_idx];
  assign fl_rd = mem[fl_idx];

  // R9: a direct low-byte write is visible after the edge
  a_r9_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> (mem[$past(lo_idx)] == $past(lo_wd)));
  // R10: a lone flat write is visible after the edge
  a_r10_flat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && !(lo_we && lo_idx == fl_idx) && !(hi_we && hi_idx == fl_idx))
      |=> (mem[$past(fl_idx)] == $past(fl_wd)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          multi_bank_i,
  input  logic          pair_sel_i,
  input  logic [7:0]    addr_i,
  input  logic          word_i,
  input  logic          we_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  input  logic [9:0]    flat_addr_i,
  input  logic          flat_we_i,
  input  logic [7:0]    flat_wdata_i,
  output logic [7:0]    flat_rdata_o
);
  logic [FW-1:0] idx_lo, idx_hi;
  logic          win_hit;
  logic [DW-1:0] rd_lo, rd_hi;
  logic          wr_lo, wr_hi;

  brf_addr_map map_i (
    .clk(clk), .rst_n(rst_n), .addr(addr_i), .wide(word_i),
    .multi(multi_bank_i), .pair(pair_sel_i),
    .idx_lo(idx_lo), .idx_hi(idx_hi), .win_hit(win_hit)
  );

  assign wr_lo = we_i;
  assign wr_hi = we_i & word_i;

  brf_storage store_i (
    .clk(clk), .rst_n(rst_n),
    .lo_idx(idx_lo), .hi_idx(idx_hi), .lo_we(wr_lo), .hi_we(wr_hi),
    .lo_wd(wdata_i[7:0]), .hi_wd(wdata_i[15:8]),
    .lo_rd(rd_lo), .hi_rd(rd_hi),
    .fl_idx(flat_addr_i), .fl_we(flat_we_i), .fl_wd(flat_wdata_i),
    .fl_rd(flat_rdata_o)
  );

  assign rdata_o = word_i ? {rd_hi, rd_lo} : {8'h00, rd_lo};

  // R2: byte reads are zero-extended
  a_r2_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !word_i |-> (rdata_o[15:8] == 8'h00));
  // R9: without any write enable the read data holds still
  a_r9_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !flat_we_i) |=> ($stable(addr_i) && $stable(word_i) &&
      $stable(multi_bank_i) && $stable(pair_sel_i)) -> $stable(rdata_o));
  // R7: window hits by word never touch the bank bits
  a_r7_window_word: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && word_i) |-> (idx_hi[FW-1:AW] == '0));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;
  logic clk = 0, rst_n = 0;
  logic multi_bank_i = 0, pair_sel_i = 0, word_i = 0, we_i = 0, flat_we_i = 0;
  logic [7:0] addr_i = 0, flat_wdata_i = 0;
  logic [15:0] wdata_i = 0;
  logic [9:0] flat_addr_i = 0;
  logic [15:0] rdata_o;
  logic [7:0] flat_rdata_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [1024];

  always #4 clk = ~clk;

  banked_regfile dut_i (.*);

  // Flat index computed from bank number and offset, the bench's own way.
  function automatic int where(input int a, input bit w, input bit m, input bit p);
    int bank, off;
    off = w ? (a / 2) * 2 : a;
    if (!m || a < 24) bank = 0;
    else if (w) bank = 2 * p + (a % 2);
    else bank = 2 * p;
    return bank * 256 + off;
  endfunction

  function automatic string tag_of(input int a, input bit w, input bit m);
    if (a < 24) return "R7";
    if (!m) return w ? "R3" : "R2";
    return w ? "R4/R5" : "R6/R5";
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Drive at negedge, check reads, then commit writes at posedge.
  task automatic op(input bit m, input bit p, input int a, input bit w, input bit we,
                    input int wd, input int fa, input bit fwe, input int fwd);
    int lo, exp;
    @(negedge clk);
    multi_bank_i = m; pair_sel_i = p; addr_i = a[7:0]; word_i = w; we_i = we;
    wdata_i = wd[15:0]; flat_addr_i = fa[9:0]; flat_we_i = fwe; flat_wdata_i = fwd[7:0];
    #1;
    lo = where(a, w, m, p);
    exp = w ? {model[lo+1], model[lo]} : {8'h00, model[lo]};
    chk(tag_of(a, w, m), rdata_o, exp);
    chk("R10", flat_rdata_o, model[fa]);
    @(posedge clk);
    if (fwe) model[fa] = fwd[7:0];
    if (we) begin
      model[lo] = wd[7:0];
      if (w) model[lo+1] = wd[15:8];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed1234);
    for (int i = 0; i < 1024; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state across all banks
    for (int i = 0; i < 1024; i += 97) op(0, 0, 0, 0, 0, 0, i, 0, 0);
    @(negedge clk); flat_addr_i = 10'h3FF; #1; chk("R1", flat_rdata_o, 0);

    // R8: multi-bank alias of word 0x3B with flat 0x13A
    op(1, 0, 8'h3B, 1, 1, 16'hBEEF, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 10'h13A, 0, 0);
    chk("R8", model[10'h13A], 8'hEF);
    op(1, 0, 8'h3B, 1, 0, 0, 10'h13B, 0, 0);
    // R8: single bank drops bit 0, 0x13A untouched
    op(0, 0, 8'h3B, 1, 1, 16'h1234, 10'h03A, 0, 0);
    op(0, 0, 0, 0, 0, 0, 10'h03A, 0, 0);
    op(0, 0, 0, 0, 0, 0, 10'h13A, 0, 0);
    @(negedge clk); flat_addr_i = 10'h13A; #1; chk("R8", flat_rdata_o, 8'hEF);
    @(negedge clk); flat_addr_i = 10'h03B; #1; chk("R3", flat_rdata_o, 8'h12);

    // R5: pair 1 odd word lands in bank 3
    op(1, 1, 8'h81, 1, 1, 16'hA55A, 0, 0, 0);
    @(negedge clk); flat_addr_i = 10'h380; #1; chk("R5", flat_rdata_o, 8'h5A);
    // R6: pair 1 odd byte lands in bank 2 at full offset
    op(1, 1, 8'h81, 0, 1, 16'h0077, 0, 0, 0);
    @(negedge clk); flat_addr_i = 10'h281; #1; chk("R6", flat_rdata_o, 8'h77);
    // R7: window word under pair 1 stays in bank 0
    op(1, 1, 8'h11, 1, 1, 16'hC3D4, 0, 0, 0);
    @(negedge clk); flat_addr_i = 10'h010; #1; chk("R7", flat_rdata_o, 8'hD4);
    @(negedge clk); flat_addr_i = 10'h311; #1; chk("R7", flat_rdata_o, 8'h00);
    // R9: we_i low leaves storage unchanged
    op(1, 1, 8'h81, 1, 0, 16'hFFFF, 0, 0, 0);
    op(1, 1, 8'h81, 1, 0, 0, 10'h381, 0, 0);
    // R10: collision, direct port wins
    op(0, 0, 8'h50, 0, 1, 16'h0011, 10'h050, 1, 8'h22);
    @(negedge clk); flat_addr_i = 10'h050; #1; chk("R10", flat_rdata_o, 8'h11);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int a, fa;
      a  = (($urandom % 4) == 0) ? ($urandom % 24) : ($urandom % 256);
      fa = (($urandom % 2) == 0) ? where(a, 1, 1, 0) : ($urandom % 1024);
      op($urandom % 2, $urandom % 2, a, $urandom % 2, ($urandom % 3) != 0,
         $urandom % 65536, fa, ($urandom % 4) == 0, $urandom % 256);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule